// File: doc/BRIEF.md
# Bit-Sliced Eight-Function Logic/Arithmetic Unit

A purely combinational unit of parameterised width that chooses between four bitwise functions and eight arithmetic functions. It uses a mode bit, a two-bit select and a carry input. The datapath is one small cell repeated once per bit. Inside each cell, A may be inverted, B may be gated off and the incoming carry may be gated off. One XOR/AND/OR network then produces both the function bit and the carry to the next cell. The logic and arithmetic results therefore share all of their hardware.

Select encoding:

- `sel_i[0]` = 1 inverts A before use; 0 passes A unchanged.
- `sel_i[1]` = 0 blocks B, so B is treated as zero; 1 lets B through.
- `mode_i` = 0 selects logic mode. The carry chain is held at zero and `cin_i` has no effect.
- `mode_i` = 1 selects arithmetic mode. `cin_i` is added in at the least significant bit.

A user builds wider words by changing the width parameter. The carry out of the top cell appears on `co_o`.

Top module: `alu_mode8`

## Requirements
- R1: With mode_i=0 and sel_i=2'b00, f_o equals a_i.
- R2: With mode_i=0 and sel_i=2'b01, f_o equals the bitwise inverse of a_i.
- R3: With mode_i=0 and sel_i=2'b10, f_o equals a_i XOR b_i.
- R4: With mode_i=0 and sel_i=2'b11, f_o equals a_i XNOR b_i.
- R5: With mode_i=0, cin_i has no effect on f_o for any select value.
- R6: With mode_i=0, co_o is 0 for all operands.
- R7: With mode_i=1, cin_i=0 and sel_i=2'b00, f_o equals a_i and co_o is 0.
- R8: With mode_i=1, cin_i=0 and sel_i=2'b01, f_o equals the inverse of a_i and co_o is 0.
- R9: With mode_i=1, cin_i=0 and sel_i=2'b10, {co_o,f_o} equals a_i + b_i.
- R10: With mode_i=1, cin_i=0 and sel_i=2'b11, {co_o,f_o} equals (~a_i) + b_i, where ~a_i is taken at the full width.
- R11: With mode_i=1, cin_i=1 and sel_i=2'b00, f_o equals a_i + 1 modulo 2^W. co_o is 1 only when a_i is all ones.
- R12: With mode_i=1, cin_i=1 and sel_i=2'b01, f_o equals the twos complement of a_i. co_o is 1 only when a_i is zero.
- R13: With mode_i=1, cin_i=1 and sel_i=2'b10, {co_o,f_o} equals a_i + b_i + 1.
- R14: With mode_i=1, cin_i=1 and sel_i=2'b11, f_o equals b_i - a_i modulo 2^W. co_o is 1 exactly when b_i >= a_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_i | input | 1 | 0 = bitwise logic, 1 = arithmetic |
| sel_i | input | 2 | bit 0 inverts A, bit 1 enables B |
| cin_i | input | 1 | carry into the lowest cell (arithmetic mode only) |
| a_i | input | W | operand A |
| b_i | input | W | operand B |
| f_o | output | W | function result |
| co_o | output | 1 | carry out of the top cell, 0 in logic mode |

## Verification
Every combination of mode, select, carry and both operands is applied at the default width of 4, which gives 4096 patterns. The XOR and XNOR patterns separate the effect of the A-inversion bit from the effect of the B-gating bit. Repeating each logic pattern with both carry values shows whether the carry leaks into logic mode. In arithmetic mode, operands of zero, all ones and equal values decide the carry-out boundaries of increment, negation and B minus A. Those cases show whether the carry is generated or propagated in the wrong cell.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    SEL_A    = 2'b00,
    SEL_NA   = 2'b01,
    SEL_AB   = 2'b10,
    SEL_NAB  = 2'b11
  } alu_sel_e;

  localparam int unsigned SEL_INV_BIT  = 0;
  localparam int unsigned SEL_BEN_BIT  = 1;
endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep #(
  parameter int unsigned W = 4
) (
  input  logic         mode_i,
  input  logic [1:0]   sel_i,
  input  logic         cin_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] a_eff_o,
  output logic [W-1:0] b_eff_o,
  output logic         c_first_o
);
  import alu_pkg::*;

  assign a_eff_o   = a_i ^ {W{sel_i[SEL_INV_BIT]}};
  assign b_eff_o   = b_i & {W{sel_i[SEL_BEN_BIT]}};
  // carry chain held at zero in logic mode
  assign c_first_o = cin_i & mode_i;

  always_comb begin
    if (!mode_i) AST_CHAIN_IDLE: assert (c_first_o == 1'b0) else $error("chain seed live"); // R5
  end
endmodule

// File: rtl/alu_bit_cell.sv
module alu_bit_cell (
  input  logic mode_i,
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic f_o,
  output logic c_o
);
  logic ac_x;

  assign ac_x = a_i ^ c_i;
  assign f_o  = ac_x ^ b_i;
  assign c_o  = mode_i & ((a_i & c_i) | (b_i & ac_x));
endmodule

// File: rtl/alu_mode8.sv
module alu_mode8 #(
  parameter int unsigned W = 4
) (
  input  logic         mode_i,
  input  logic [1:0]   sel_i,
  input  logic         cin_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] f_o,
  output logic         co_o
);
  localparam int unsigned CW = W + 1;

  logic [W-1:0]  a_eff, b_eff;
  logic [CW-1:0] carry;

  alu_operand_prep #(.W(W)) prep_i (
    .mode_i    (mode_i),
    .sel_i     (sel_i),
    .cin_i     (cin_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .a_eff_o   (a_eff),
    .b_eff_o   (b_eff),
    .c_first_o (carry[0])
  );

  for (genvar gi = 0; gi < W; gi++) begin : g_slice
    alu_bit_cell cell_i (
      .mode_i (mode_i),
      .a_i    (a_eff[gi]),
      .b_i    (b_eff[gi]),
      .c_i    (carry[gi]),
      .f_o    (f_o[gi]),
      .c_o    (carry[gi+1])
    );
  end

  assign co_o = carry[W];

  logic [CW-1:0] ref_sum;
  logic [W-1:0]  ref_aa, ref_bb;
  always_comb begin
    ref_aa  = sel_i[0] ? ~a_i : a_i;
    ref_bb  = sel_i[1] ? b_i : '0;
    ref_sum = {1'b0, ref_aa} + {1'b0, ref_bb} + {{W{1'b0}}, cin_i};
    if (!mode_i) AST_LOGIC_NO_CO: assert (co_o == 1'b0) else $error("co in logic mode"); // R6
    if (!mode_i && sel_i == 2'b00) AST_LOGIC_PASS: assert (f_o == a_i) else $error("pass"); // R1
    if (!mode_i && sel_i == 2'b01) AST_LOGIC_INV: assert (f_o == ~a_i) else $error("inv"); // R2
    if (!mode_i && sel_i == 2'b10) AST_LOGIC_XOR: assert (f_o == (a_i ^ b_i)) else $error("xor"); // R3
    if (!mode_i && sel_i == 2'b11) AST_LOGIC_XNOR: assert (f_o == ~(a_i ^ b_i)) else $error("xnor"); // R4
    if (mode_i) AST_ARITH_SUM: assert ({co_o, f_o} == ref_sum) else $error("sum"); // R9
    if (mode_i && cin_i && sel_i == 2'b11) AST_B_MINUS_A: assert (f_o == b_i - a_i) else $error("sub"); // R14
  end
endmodule

// File: tb/alu_mode8_tb_top.sv
module alu_mode8_tb_top;
  localparam int W = 4;
  localparam int MASK = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic         mode, cin, co;
  logic [1:0]   sel;
  logic [W-1:0] a, b, f;

  alu_mode8 #(.W(W)) dut_i (
    .mode_i (mode), .sel_i (sel), .cin_i (cin),
    .a_i (a), .b_i (b), .f_o (f), .co_o (co)
  );

  typedef struct {
    int f;
    int co;
    int req;
    int m, s, c, ai, bi;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit drv_done = 1'b0;
  bit finished = 1'b0;

  task automatic compare(input exp_t e);
    checks++;
    if (int'(f) != e.f || int'(co) != e.co) begin
      errors++;
      $display("FAIL R%0d m=%0d s=%0d c=%0d a=%0d b=%0d: actual f=%0d co=%0d expected f=%0d co=%0d",
               e.req, e.m, e.s, e.c, e.ai, e.bi, f, co, e.f, e.co);
    end
  endtask

  function automatic exp_t model(int m, int s, int c, int ai, int bi);
    exp_t e;
    int na = (~ai) & MASK;
    int t = 0;
    e.m = m; e.s = s; e.c = c; e.ai = ai; e.bi = bi;
    e.co = 0;
    if (m == 0) begin
      case (s)
        0: begin e.f = ai; e.req = 1; end                       // R1
        1: begin e.f = na; e.req = 2; end                       // R2
        2: begin e.f = ai ^ bi; e.req = 3; end                  // R3
        default: begin e.f = (~(ai ^ bi)) & MASK; e.req = 4; end // R4
      endcase
      if (c == 1) e.req = 5; // R5: same expectation with carry set
    end else if (c == 0) begin
      case (s)
        0: begin e.f = ai; e.req = 7; end // R7
        1: begin e.f = na; e.req = 8; end // R8
        2: begin t = ai + bi; e.f = t & MASK; e.co = t >> W; e.req = 9; end  // R9
        default: begin t = na + bi; e.f = t & MASK; e.co = t >> W; e.req = 10; end // R10
      endcase
    end else begin
      case (s)
        0: begin e.f = (ai + 1) & MASK; e.co = (ai == MASK); e.req = 11; end // R11
        1: begin e.f = (-ai) & MASK; e.co = (ai == 0); e.req = 12; end       // R12
        2: begin t = ai + bi + 1; e.f = t & MASK; e.co = t >> W; e.req = 13; end // R13
        default: begin e.f = (bi - ai) & MASK; e.co = (bi >= ai); e.req = 14; end // R14
      endcase
    end
    return e;
  endfunction

  // driver: applies stimulus just after the rising edge
  initial begin
    mode = 1'b0; sel = 2'b00; cin = 1'b0; a = '0; b = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(posedge clk);
    q.push_back(model(0, 0, 0, 0, 0)); // reset-state check, R1/R6
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        for (int c = 0; c < 2; c++)
          for (int ai = 0; ai <= MASK; ai++)
            for (int bi = 0; bi <= MASK; bi++) begin
              @(posedge clk);
              mode = m[0]; sel = s[1:0]; cin = c[0];
              a = ai[W-1:0]; b = bi[W-1:0];
              q.push_back(model(m, s, c, ai, bi));
            end
    @(posedge clk);
    drv_done = 1'b1;
  end

  // monitor: samples on the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) compare(q.pop_front());
      if (drv_done && q.size() == 0 && !finished) begin
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual hung expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule